// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block takes one position record from a host processor and sends it out as a gated synchronous serial frame. The host writes the record as four 16-bit words through a small address window. A 4-bit code in that window is decoded one-of-16, and the whole decoder is enabled by one higher address bit. The record is ready for sending only after each of the four word slots has been written at least once.

The block runs entirely on the bit clock that it receives from the far end. The far end asks for a frame by pulsing a request line. When the request falls back low and a complete record is held, the block waits a fixed guard time. It then raises a gate line for exactly 72 bit periods. During those periods it shifts out, most significant bit first, a start byte, the seven record bytes and an end byte. Outside a frame the gate and data lines are held low.

Top module: `sync_frame_tx`

## Requirements
- R1: After synchronous reset, `gate_out` and `data_out` are low and the record is empty, so a request before any write produces no frame.
- R2: A frame is 72 bits sent most significant bit first: byte 0x02, then the seven record bytes, then byte 0x03.
- R3: Slot 0 supplies record bytes 1–2, slot 1 bytes 3–4 and slot 2 bytes 5–6, each upper byte first. Slot 3 supplies byte 7 from its bits 15:8. Bits 7:0 of slot 3 never appear on the line.
- R4: A write is captured only when `host_addr[4]` is 1 and `host_addr[3:0]` is 0, 1, 2 or 3, which selects slot 0 to 3. Every other address leaves the record unchanged.
- R5: A write to a slot that already holds data overwrites that slot and does not count toward completion. A record is complete only when all four slots have been written.
- R6: A falling edge of `req_in` seen while the record is incomplete sends no frame, and `gate_out` stays low.
- R7: When `req_in` is sampled high at one rising edge and low at the next (edge E), and the record is complete, `gate_out` rises at edge E+10.
- R8: `gate_out` stays high for exactly 72 clock periods and carries one data bit per period. Both outputs change only on rising clock edges.
- R9: Whenever `gate_out` is low, `data_out` is low.
- R10: A request falling edge that arrives while a frame is in its guard time or its shifting phase is ignored.
- R11: Starting a frame empties the record. Another frame needs four fresh slot writes, which may be made while the current frame is still shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Received bit clock; every register uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per word |
| host_addr | input | 5 | Bit 4 enables the decoder; bits 3:0 are the decoded code |
| host_wdata | input | 16 | Host write data |
| req_in | input | 1 | Frame request strobe from the far end |
| gate_out | output | 1 | High while frame bits are on `data_out` |
| data_out | output | 1 | Serial frame data, MSB first |

## Verification
The in-line assertions check several rules on every cycle. Data stays low while the gate is low. Each gate-high run lasts exactly 72 cycles. The gate rises ten cycles after an accepted request. A request against an incomplete record never leaves the idle state. Rewriting a filled slot leaves the completion mask unchanged. The bench scenarios cover the properties that depend on content: the bit order and byte mapping of whole frames, including the discarded low byte of slot 3, over several arithmetic patterns. They also sweep all 32 window addresses to show that non-slot writes leave the record untouched. Finally they check that requests made mid-frame are dropped and that the record is emptied once it has been sent.

// File: rtl/sft_pkg.sv
// Shared constants and types for the synchronous frame transmitter.
package sft_pkg;
    localparam int WORD_W    = 16;
    localparam int N_WORDS   = 4;
    localparam int BYTE_W    = 8;
    localparam int CODE_W    = 4;
    localparam int GUARD_CYC = 10;
    localparam logic [BYTE_W-1:0] SOF_BYTE = 8'h02;
    localparam logic [BYTE_W-1:0] EOF_BYTE = 8'h03;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GUARD = 2'd1,
        ST_SHIFT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/addr_decoder.sv
// One-of-N address decoder.
// Assumes: the code is stable in the same cycle as the enable; no registers.
module addr_decoder #(
    parameter int CODE_W = 4,
    localparam int LINES = 1 << CODE_W
) (
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic [LINES-1:0]  hot
);
    // One output line per code value, each gated by the enable.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign hot[i] = en && (code == CODE_W'(i));
    end
endmodule

// File: rtl/record_store.sv
// Holds the host words of one record and tracks which slots have been filled.
// Assumes: one write per cycle at most; consume empties the mask, but a
// write in the same cycle still marks its own slot.
module record_store #(
    parameter int WORD_W    = 16,
    parameter int N_WORDS   = 4,
    parameter int LINES     = 16,
    parameter int SLOT_BASE = 0,
    localparam int REC_W    = WORD_W * N_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LINES-1:0]  line_hot,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              consume,
    output logic [REC_W-1:0]  rec_words,
    output logic              complete
);
    logic [N_WORDS-1:0] sel;
    logic [N_WORDS-1:0] mask_q;

    for (genvar i = 0; i < N_WORDS; i++) begin : g_slot
        logic [WORD_W-1:0] word_q;

        // Slot select from the decoded address line.
        assign sel[i] = wr_en && line_hot[SLOT_BASE + i];

        // Capture the host word when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (sel[i])
                word_q <= wr_data;
        end

        // Slot 0 occupies the most significant word.
        assign rec_words[(N_WORDS-1-i)*WORD_W +: WORD_W] = word_q;
    end

    // Filled-slot mask: emptied on consume, set per written slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else
            mask_q <= (consume ? '0 : mask_q) | sel;
    end

    assign complete = &mask_q;

    // R5: rewriting an already-filled slot does not change the mask.
    p_rewrite_no_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!consume && ((sel & ~mask_q) == '0)) |=> (mask_q == $past(mask_q)));

    // R4: at most one slot is written per cycle.
    p_single_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/frame_sequencer.sv
// Detects the falling edge of the request strobe, waits the guard time and
// shifts out the framed record MSB first while the gate is held high.
// Assumes: req_in is synchronous to clk; GUARD_CYC >= 1.
module frame_sequencer
    import sft_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int N_WORDS   = 4,
    parameter int BYTE_W    = 8,
    parameter int GUARD_CYC = 10,
    parameter logic [BYTE_W-1:0] SOF = 8'h02,
    parameter logic [BYTE_W-1:0] EOF = 8'h03,
    localparam int REC_W    = WORD_W * N_WORDS,
    localparam int FRAME_W  = 2 * BYTE_W + REC_W - BYTE_W,
    localparam int CNT_MAX  = (FRAME_W > GUARD_CYC) ? FRAME_W : GUARD_CYC,
    localparam int CNT_W    = $clog2(CNT_MAX + 1),
    localparam int RUN_W    = $clog2(FRAME_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    input  logic             complete,
    input  logic [REC_W-1:0] rec_words,
    output logic             consume,
    output logic             gate_out,
    output logic             data_out
);
    seq_state_t         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] shreg_q;
    logic               req_q;
    logic               gate_q;
    logic               data_q;
    logic               req_fall;
    logic               start;
    logic [FRAME_W-1:0] frame;

    // Assemble the frame: start byte, record without the last low byte, end byte.
    assign frame    = {SOF, rec_words[REC_W-1:BYTE_W], EOF};
    assign req_fall = req_q && !req_in;
    assign start    = req_fall && (state_q == ST_IDLE) && complete;
    assign consume  = start;

    // Previous-cycle copy of the request strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else
            req_q <= req_in;
    end

    // Sequencer: idle, guard countdown, then shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            gate_q  <= 1'b0;
            data_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        shreg_q <= frame;
                        cnt_q   <= CNT_W'(GUARD_CYC - 1);
                        state_q <= ST_GUARD;
                    end
                end
                ST_GUARD: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_SHIFT;
                        gate_q  <= 1'b1;
                        data_q  <= shreg_q[FRAME_W-1];
                        shreg_q <= shreg_q << 1;
                        cnt_q   <= CNT_W'(FRAME_W - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_IDLE;
                        gate_q  <= 1'b0;
                        data_q  <= 1'b0;
                    end else begin
                        data_q  <= shreg_q[FRAME_W-1];
                        shreg_q <= shreg_q << 1;
                        cnt_q   <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign gate_out = gate_q;
    assign data_out = data_q;

    // Checker state: length of the current gate-high run.
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (gate_q)
            run_q <= run_q + 1'b1;
        else
            run_q <= '0;
    end

    // Checker state: cycles since the last accepted request (saturating).
    logic [4:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= '1;
        else if (start)
            since_q <= '0;
        else if (since_q != '1)
            since_q <= since_q + 1'b1;
    end

    // R9: data is low whenever the gate is low.
    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_out |-> !data_out);

    // R8: the gate never stays high for more than the frame length.
    p_gate_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_out |-> (run_q < RUN_W'(FRAME_W)));

    // R8: the gate falls only after exactly the frame length.
    p_gate_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_out) |-> (run_q == RUN_W'(FRAME_W)));

    // R7: the gate rises exactly the guard time after an accepted request.
    p_guard_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_out) |-> (since_q == 5'(GUARD_CYC)));

    // R6: a request against an incomplete record leaves the sequencer idle.
    p_no_start_incomplete_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fall && !complete && state_q == ST_IDLE) |=> (state_q == ST_IDLE));

    // R2: the first bit on the line is the MSB of the start byte.
    p_first_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_out) |-> (data_out == SOF[BYTE_W-1]));
endmodule

// File: rtl/sync_frame_tx.sv
// Top of the synchronous serial frame transmitter: host window decode,
// record storage and frame sequencing, all on the received bit clock.
// Assumes: host writes are synchronous to clk.
module sync_frame_tx
    import sft_pkg::*;
#(
    parameter int SLOT_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [CODE_W:0]   host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              req_in,
    output logic              gate_out,
    output logic              data_out
);
    localparam int LINES = 1 << CODE_W;
    localparam int REC_W = WORD_W * N_WORDS;

    logic [LINES-1:0] line_hot;
    logic [REC_W-1:0] rec_words;
    logic             complete;
    logic             consume;

    addr_decoder #(.CODE_W(CODE_W)) u_dec (
        .en   (host_addr[CODE_W]),
        .code (host_addr[CODE_W-1:0]),
        .hot  (line_hot)
    );

    record_store #(
        .WORD_W    (WORD_W),
        .N_WORDS   (N_WORDS),
        .LINES     (LINES),
        .SLOT_BASE (SLOT_BASE)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr),
        .line_hot  (line_hot),
        .wr_data   (host_wdata),
        .consume   (consume),
        .rec_words (rec_words),
        .complete  (complete)
    );

    frame_sequencer #(
        .WORD_W    (WORD_W),
        .N_WORDS   (N_WORDS),
        .BYTE_W    (BYTE_W),
        .GUARD_CYC (GUARD_CYC),
        .SOF       (SOF_BYTE),
        .EOF       (EOF_BYTE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_in),
        .complete  (complete),
        .rec_words (rec_words),
        .consume   (consume),
        .gate_out  (gate_out),
        .data_out  (data_out)
    );
endmodule

// File: tb/sim_sync_frame_tx.sv
// Self-checking bench for sync_frame_tx.
module sim_sync_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        req_in = 1'b0;
    logic        gate_out;
    logic        data_out;

    int checks = 0;
    int fails  = 0;

    sync_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .req_in(req_in),
        .gate_out(gate_out), .data_out(data_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One host write: driven at a falling edge, captured at the next rising edge.
    task automatic host_write(input logic en, input logic [3:0] code, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = {en, code}; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    endtask

    task automatic fill(input logic [15:0] w0, w1, w2, w3);
        host_write(1'b1, 4'd0, w0);
        host_write(1'b1, 4'd1, w1);
        host_write(1'b1, 4'd2, w2);
        host_write(1'b1, 4'd3, w3);
    endtask

    function automatic logic [71:0] mk_frame(input logic [15:0] w0, w1, w2, w3);
        return {8'h02, w0, w1, w2, w3[15:8], 8'h03};
    endfunction

    // Request pulse of 10 cycles, then watch the window cycle by cycle.
    // The k-th falling edge after the request drops follows rising edge E+k-1.
    // With mid set, four slot writes and a second request are made mid-frame.
    task automatic run_req(input string tag, input logic expect_frame,
                           input logic [71:0] fr, input logic mid,
                           input logic [15:0] m0, m1, m2, m3);
        logic g_exp, d_exp;
        @(negedge clk); req_in = 1'b1;
        repeat (10) @(negedge clk);
        req_in = 1'b0;
        for (int k = 1; k <= 110; k++) begin
            @(negedge clk);
            g_exp = expect_frame && (k >= 11) && (k <= 82);
            d_exp = g_exp ? fr[71 - (k - 11)] : 1'b0;
            chk({tag, " gate"}, gate_out, g_exp);
            chk({tag, " data"}, data_out, d_exp);
            host_wr = 1'b0; host_addr = '0; host_wdata = '0;
            if (mid) begin
                if (k >= 20 && k <= 23) begin
                    host_wr   = 1'b1;
                    host_addr = {1'b1, 4'(k - 20)};
                    host_wdata = (k == 20) ? m0 : (k == 21) ? m1 : (k == 22) ? m2 : m3;
                end
                if (k == 30) req_in = 1'b1;
                if (k == 40) req_in = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] a, b, c, d;
        repeat (4) @(negedge clk);
        // R1: outputs low during and right after reset
        chk("R1 gate in reset", gate_out, 1'b0);
        chk("R1 data in reset", data_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 gate after reset", gate_out, 1'b0);
        chk("R1 data after reset", data_out, 1'b0);
        // R1/R6: empty record, request sends nothing
        run_req("R1 empty record", 1'b0, '0, 1'b0, '0, '0, '0, '0);

        // R6: three of four slots, no frame; R2/R3/R7/R8: fourth completes
        host_write(1'b1, 4'd0, 16'hA1B2);
        host_write(1'b1, 4'd1, 16'hC3D4);
        host_write(1'b1, 4'd2, 16'hE5F6);
        run_req("R6 incomplete", 1'b0, '0, 1'b0, '0, '0, '0, '0);
        host_write(1'b1, 4'd3, 16'h97FF);
        run_req("R2 R7 R8 first frame", 1'b1, mk_frame(16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h97FF),
                1'b0, '0, '0, '0, '0);
        // R11: record consumed, a repeat request sends nothing
        run_req("R11 consumed", 1'b0, '0, 1'b0, '0, '0, '0, '0);

        // R5: rewrite slot 0, no completion until slot 3, last value wins
        host_write(1'b1, 4'd0, 16'h1111);
        host_write(1'b1, 4'd0, 16'h8001);
        host_write(1'b1, 4'd1, 16'h0F0F);
        host_write(1'b1, 4'd1, 16'h7E7E);
        host_write(1'b1, 4'd2, 16'h5AA5);
        run_req("R5 repeat no advance", 1'b0, '0, 1'b0, '0, '0, '0, '0);
        host_write(1'b1, 4'd3, 16'hC300);
        run_req("R5 overwrite value", 1'b1, mk_frame(16'h8001, 16'h7E7E, 16'h5AA5, 16'hC300),
                1'b0, '0, '0, '0, '0);

        // R4: sweep all non-slot addresses after loading a known record
        fill(16'h0123, 16'h4567, 16'h89AB, 16'hCDEF);
        for (int code = 0; code < 16; code++) begin
            host_write(1'b0, 4'(code), 16'hFFFF - 16'(code));
            if (code >= 4) host_write(1'b1, 4'(code), 16'h0000 + 16'(code * 4369));
        end
        run_req("R4 decode sweep", 1'b1, mk_frame(16'h0123, 16'h4567, 16'h89AB, 16'hCDEF),
                1'b0, '0, '0, '0, '0);

        // R2/R3: arithmetic patterns, slot 3 low byte varied and never sent
        for (int i = 0; i < 5; i++) begin
            a = 16'(i * 16'h1357 + 16'h0101);
            b = 16'(i * 16'h2468 + 16'h8000);
            c = 16'(16'hFFFF - i * 16'h0F1E);
            d = 16'((i * 16'h3C00) | (16'h00FF >> i));
            fill(a, b, c, d);
            run_req("R3 R2 pattern", 1'b1, mk_frame(a, b, c, d), 1'b0, '0, '0, '0, '0);
        end

        // R10/R11: mid-frame writes and request; request ignored, new record kept
        fill(16'hF00D, 16'hBEEF, 16'h1234, 16'h5678);
        run_req("R10 mid-frame request", 1'b1, mk_frame(16'hF00D, 16'hBEEF, 16'h1234, 16'h5678),
                1'b1, 16'h0246, 16'h8ACE, 16'h1357, 16'h9BDF);
        run_req("R11 mid-frame record", 1'b1, mk_frame(16'h0246, 16'h8ACE, 16'h1357, 16'h9BDF),
                1'b0, '0, '0, '0, '0);

        // R1: reset mid-record empties it
        host_write(1'b1, 4'd0, 16'h1);
        host_write(1'b1, 4'd1, 16'h2);
        host_write(1'b1, 4'd2, 16'h3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        host_write(1'b1, 4'd3, 16'h4);
        run_req("R1 reset clears record", 1'b0, '0, 1'b0, '0, '0, '0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule